// File: doc/BRIEF.md
# Three-Wire Configuration Word Receiver

This block receives a 24-bit configuration word over a three-wire serial port: a serial clock, a data line and a load strobe. All three lines are asynchronous to the system clock. They are brought into the system clock domain, and the rising edges of the serial clock are detected there. On each serial clock rising edge, the data bit enters a shift register, most significant bit first.

A rising strobe copies the shift register into the active configuration. While the strobe stays high, every further serial clock edge moves the freshly shifted word straight into the active configuration, so the outputs follow bit by bit. The active word is decoded into six fields:

- reference divider
- VCO divider
- output divider select
- secondary-output function
- duty-cycle trim bit
- crystal load code

A one-cycle pulse marks every load. A load that carries an illegal divider code still updates the other fields, but it keeps the previous divider values and raises an error flag.

A parameter chooses the reset state. One variant resets to a word that gives a unity input-to-output frequency ratio with the secondary output on the reference. The other variant resets the whole configuration to zero.

Top module: `cfg3w_rx`

## Requirements
- R1: Each rising edge of the synchronized serial clock shifts the synchronized data bit into a 24-bit register, most significant bit first. The first bit sent ends in bit 23 and the last bit sent ends in bit 0. The register changes on no other cycle.
- R2: A rising edge of the synchronized strobe copies the shift register into the active configuration. In the same cycle that the outputs take the new value, `upd_o` is high for exactly one cycle.
- R3: While the synchronized strobe is high, every serial clock rising edge loads the newly shifted word (including that edge's bit) into the active configuration. Each such edge gives one `upd_o` pulse.
- R4: The active word decodes as follows: bits 23:22 are `cap_o`, bit 21 is `duty_o`, bits 20:19 are `aux_fn_o`, bits 18:16 are `odsel_o`, bits 15:7 are `vco_div_o` and bits 6:0 are `ref_div_o`. The bytes 0x31, 0x8A, 0x3B give cap 0, duty 1, aux 2, odsel 1, VCO 276 and reference 59.
- R5: A load with a VCO code below 4 or a reference code of 0 keeps both previous divider outputs, still updates the other four fields, and sets `div_err_o` to 1. A load with VCO 4 or above and reference 1 or above clears `div_err_o`.
- R6: With `DEFAULT_ON`=1, reset gives cap 0, duty 1, aux 0, odsel 1, VCO 12, reference 18, `div_err_o`=0 and `upd_o`=0.
- R7: With `DEFAULT_ON`=0, reset gives every field output, `div_err_o` and `upd_o` equal to 0.
- R8: While the strobe stays low, serial clock pulses leave every output unchanged and give no `upd_o` pulse.
- R9: A falling strobe neither loads the configuration nor pulses `upd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_ld_i | input | 1 | Load strobe, asynchronous |
| ref_div_o | output | 7 | Active reference divider code |
| vco_div_o | output | 9 | Active VCO divider code |
| odsel_o | output | 3 | Active output divider select |
| aux_fn_o | output | 2 | Active secondary-output function |
| duty_o | output | 1 | Active duty-cycle trim bit |
| cap_o | output | 2 | Active crystal load code |
| div_err_o | output | 1 | Last load carried an illegal divider code |
| upd_o | output | 1 | One-cycle pulse on each configuration load |

## Verification
The serial lines reach the logic only after the synchronizer stages and one edge-detect register. A wrong shift register, strobe-edge history or divider-legality state therefore stays hidden until the next load. It then shows as a wrong field value, a wrong error flag or a missing or extra `upd_o` pulse, SYNC_STAGES+1 clock cycles after the line changed at the pin.

A cycle-accurate reference model compared on every clock catches such a fault in that cycle. Directed loads also check the bit order, the transparent-strobe mode, the illegal-code boundaries and both reset variants.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
    localparam int CAP_W  = 2;
    localparam int DUTY_W = 1;
    localparam int AUX_W  = 2;
    localparam int OD_W   = 3;
    localparam int VCO_W  = 9;
    localparam int REF_W  = 7;
    localparam int WORD_W = CAP_W + DUTY_W + AUX_W + OD_W + VCO_W + REF_W;

    localparam int VCO_MIN = 4;
    localparam int REF_MIN = 1;

    typedef struct packed {
        logic [CAP_W-1:0]  cap;
        logic [DUTY_W-1:0] duty;
        logic [AUX_W-1:0]  aux;
        logic [OD_W-1:0]   odsel;
        logic [VCO_W-1:0]  vco;
        logic [REF_W-1:0]  refd;
    } cfg_t;

    function automatic logic div_legal(input cfg_t c);
        return (int'(c.vco) >= VCO_MIN) && (int'(c.refd) >= REF_MIN);
    endfunction
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
    end

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_chain
            always_comb begin
                stg_d[k] = stg_q[k-1];
            end
        end
        for (k = 0; k < STAGES; k++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[k] <= '0;
                else        stg_q[k] <= stg_d[k];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              dat_s,
    input  logic              stb_s,
    output logic              sclk_rise,
    output logic              stb_rise,
    output logic              stb_fall,
    output logic [WORD_W-1:0] word_now,
    output logic [WORD_W-1:0] word_next
);
    typedef struct packed {
        logic              sclk_prev;
        logic              stb_prev;
        logic [WORD_W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        sclk_rise      = sclk_s & ~st_q.sclk_prev;
        stb_rise       = stb_s & ~st_q.stb_prev;
        stb_fall       = ~stb_s & st_q.stb_prev;
        st_d.sclk_prev = sclk_s;
        st_d.stb_prev  = stb_s;
        if (sclk_rise) st_d.sh = {st_q.sh[WORD_W-2:0], dat_s};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_now  = st_q.sh;
    assign word_next = st_d.sh;

    assert_shift_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(word_now))
        else $error("shift register moved without a serial clock edge");
endmodule

// File: rtl/cfg3w_latch.sv
module cfg3w_latch
    import cfg3w_pkg::*;
#(
    parameter bit          DEFAULT_ON = 1'b1,
    parameter logic [WORD_W-1:0] DEF_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              stb_rise,
    input  logic              stb_fall,
    input  logic              stb_lvl,
    input  logic [WORD_W-1:0] word_now,
    input  logic [WORD_W-1:0] word_next,
    output cfg_t              cfg_o,
    output logic              err_o,
    output logic              upd_o
);
    typedef struct packed {
        cfg_t cfg;
        logic err;
        logic upd;
    } lat_st_t;

    localparam cfg_t RST_CFG = DEFAULT_ON ? cfg_t'(DEF_WORD) : cfg_t'('0);

    lat_st_t st_d, st_q;
    logic    thru;
    logic    load;
    cfg_t    cand;

    always_comb begin
        thru = stb_lvl & sclk_rise;
        load = thru | stb_rise;
        cand = thru ? cfg_t'(word_next) : cfg_t'(word_now);
        st_d = st_q;
        st_d.upd = load;
        if (load) begin
            st_d.cfg.cap   = cand.cap;
            st_d.cfg.duty  = cand.duty;
            st_d.cfg.aux   = cand.aux;
            st_d.cfg.odsel = cand.odsel;
            if (div_legal(cand)) begin
                st_d.cfg.vco  = cand.vco;
                st_d.cfg.refd = cand.refd;
                st_d.err      = 1'b0;
            end else begin
                st_d.err      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cfg: RST_CFG, err: 1'b0, upd: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign err_o = st_q.err;
    assign upd_o = st_q.upd;

    assert_transparent_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_lvl && sclk_rise) |=> upd_o)
        else $error("edge under high strobe gave no load");

    assert_fall_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_fall && !sclk_rise) |=> !upd_o)
        else $error("falling strobe produced a load");
endmodule

// File: rtl/cfg3w_rx.sv
module cfg3w_rx
    import cfg3w_pkg::*;
#(
    parameter bit             DEFAULT_ON  = 1'b1,
    parameter int             SYNC_STAGES = 2,
    parameter logic [CAP_W-1:0]  DEF_CAP  = '0,
    parameter logic [DUTY_W-1:0] DEF_DUTY = 1'b1,
    parameter logic [AUX_W-1:0]  DEF_AUX  = '0,
    parameter logic [OD_W-1:0]   DEF_OD   = 3'd1,
    parameter logic [VCO_W-1:0]  DEF_VCO  = 9'd12,
    parameter logic [REF_W-1:0]  DEF_REF  = 7'd18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_ld_i,
    output logic [REF_W-1:0] ref_div_o,
    output logic [VCO_W-1:0] vco_div_o,
    output logic [OD_W-1:0]  odsel_o,
    output logic [AUX_W-1:0] aux_fn_o,
    output logic             duty_o,
    output logic [CAP_W-1:0] cap_o,
    output logic             div_err_o,
    output logic             upd_o
);
    localparam logic [WORD_W-1:0] DEF_WORD =
        {DEF_CAP, DEF_DUTY, DEF_AUX, DEF_OD, DEF_VCO, DEF_REF};

    logic [2:0]        sync_v;
    logic              sclk_rise, stb_rise, stb_fall;
    logic [WORD_W-1:0] word_now, word_next;
    cfg_t              cfg;

    cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_ld_i, ser_dat_i, ser_clk_i}),
        .sync_o  (sync_v)
    );

    cfg3w_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sync_v[0]),
        .dat_s     (sync_v[1]),
        .stb_s     (sync_v[2]),
        .sclk_rise (sclk_rise),
        .stb_rise  (stb_rise),
        .stb_fall  (stb_fall),
        .word_now  (word_now),
        .word_next (word_next)
    );

    cfg3w_latch #(.DEFAULT_ON(DEFAULT_ON), .DEF_WORD(DEF_WORD)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .stb_rise  (stb_rise),
        .stb_fall  (stb_fall),
        .stb_lvl   (sync_v[2]),
        .word_now  (word_now),
        .word_next (word_next),
        .cfg_o     (cfg),
        .err_o     (div_err_o),
        .upd_o     (upd_o)
    );

    assign ref_div_o = cfg.refd;
    assign vco_div_o = cfg.vco;
    assign odsel_o   = cfg.odsel;
    assign aux_fn_o  = cfg.aux;
    assign duty_o    = cfg.duty;
    assign cap_o     = cfg.cap;

    assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable({cap_o, duty_o, aux_fn_o, odsel_o, vco_div_o, ref_div_o, div_err_o}))
        else $error("outputs moved without a load pulse");

    generate
        if (DEFAULT_ON) begin : g_legal_chk
            assert_legal_divs_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(vco_div_o) >= VCO_MIN) && (int'(ref_div_o) >= REF_MIN))
                else $error("illegal divider code reached the outputs");
        end
    endgenerate
endmodule

// File: tb/cfg3w_rx_test.sv
module cfg3w_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sstb = 1'b0;

    logic [6:0] ref_o, ref_z;
    logic [8:0] vco_o, vco_z;
    logic [2:0] od_o, od_z;
    logic [1:0] aux_o, aux_z, cap_o, cap_z;
    logic duty_o, duty_z, err_o, err_z, upd_o, upd_z;

    int checks = 0, bad = 0, cycles = 0, updcnt = 0;
    localparam int SYNC = 2;

    always #4 clk = ~clk;

    cfg3w_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sstb),
        .ref_div_o(ref_o), .vco_div_o(vco_o), .odsel_o(od_o), .aux_fn_o(aux_o),
        .duty_o(duty_o), .cap_o(cap_o), .div_err_o(err_o), .upd_o(upd_o));

    cfg3w_rx #(.DEFAULT_ON(1'b0)) uut_zero (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sstb),
        .ref_div_o(ref_z), .vco_div_o(vco_z), .odsel_o(od_z), .aux_fn_o(aux_z),
        .duty_o(duty_z), .cap_o(cap_z), .div_err_o(err_z), .upd_o(upd_z));

    // behavioural reference model
    bit q_c[$], q_d[$], q_s[$];
    bit m_scp, m_stp, m_upd, m_err, m_rise, m_srise, m_sc, m_dt, m_st;
    logic [23:0] m_sh, m_nsh, m_w;
    int m_cap, m_duty, m_aux, m_od, m_vco, m_ref;

    task automatic model_apply(input logic [23:0] w);
        m_cap = int'(w[23:22]); m_duty = int'(w[21]); m_aux = int'(w[20:19]);
        m_od = int'(w[18:16]);
        if (w[15:7] >= 4 && w[6:0] >= 1) begin
            m_vco = int'(w[15:7]); m_ref = int'(w[6:0]); m_err = 1'b0;
        end else m_err = 1'b1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_c.delete(); q_d.delete(); q_s.delete();
            for (int i = 0; i < SYNC; i++) begin q_c.push_back(0); q_d.push_back(0); q_s.push_back(0); end
            m_scp = 0; m_stp = 0; m_upd = 0; m_err = 0; m_sh = '0;
            m_cap = 0; m_duty = 1; m_aux = 0; m_od = 1; m_vco = 12; m_ref = 18;
        end else begin
            m_sc = q_c[0]; m_dt = q_d[0]; m_st = q_s[0];
            m_rise = m_sc && !m_scp;
            m_srise = m_st && !m_stp;
            m_nsh = m_rise ? {m_sh[22:0], m_dt} : m_sh;
            m_upd = 1'b0;
            if ((m_st && m_rise) || m_srise) begin
                m_w = (m_st && m_rise) ? m_nsh : m_sh;
                m_upd = 1'b1;
                model_apply(m_w);
            end
            m_sh = m_nsh; m_scp = m_sc; m_stp = m_st;
            void'(q_c.pop_front()); void'(q_d.pop_front()); void'(q_s.pop_front());
            q_c.push_back(sclk); q_d.push_back(sdat); q_s.push_back(sstb);
        end
    end

    // per-cycle comparison against the model (R4 decode, R2/R3 timing)
    always @(negedge clk) begin
        cycles++;
        if (upd_o) updcnt++;
        if (rst_n) begin
            checks++;
            if (int'(cap_o) != m_cap || int'(duty_o) != m_duty || int'(aux_o) != m_aux ||
                int'(od_o) != m_od || int'(vco_o) != m_vco || int'(ref_o) != m_ref ||
                err_o != m_err || upd_o != m_upd) begin
                bad++;
                $display("FAIL R4 per-cycle model: got cap=%0d duty=%0d aux=%0d od=%0d vco=%0d ref=%0d err=%0d upd=%0d exp %0d %0d %0d %0d %0d %0d %0d %0d",
                    cap_o, duty_o, aux_o, od_o, vco_o, ref_o, err_o, upd_o,
                    m_cap, m_duty, m_aux, m_od, m_vco, m_ref, m_err, m_upd);
            end
        end
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [23:0] mk(input int c, input int d, input int a,
                                       input int o, input int v, input int r);
        return {c[1:0], d[0], a[1:0], o[2:0], v[8:0], r[6:0]};
    endfunction

    task automatic send(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk); sdat = w[i]; sclk = 1'b0;
            wait_clk(3); sclk = 1'b1;
            wait_clk(3); sclk = 1'b0;
        end
        wait_clk(6);
    endtask

    task automatic strobe();
        @(negedge clk); sstb = 1'b1;
        wait_clk(5); sstb = 1'b0;
        wait_clk(8);
    endtask

    task automatic chk_fields(input string tag, input int c, input int d, input int a,
                              input int o, input int v, input int r, input int e);
        chk({tag, " cap"}, int'(cap_o), c);
        chk({tag, " duty"}, int'(duty_o), d);
        chk({tag, " aux"}, int'(aux_o), a);
        chk({tag, " odsel"}, int'(od_o), o);
        chk({tag, " vco"}, int'(vco_o), v);
        chk({tag, " ref"}, int'(ref_o), r);
        chk({tag, " err"}, int'(err_o), e);
    endtask

    initial begin
        wait_clk(4);
        chk_fields("R6 reset default", 0, 1, 0, 1, 12, 18, 0);
        chk("R6 reset upd", int'(upd_o), 0);
        chk("R7 reset zero word", int'({cap_z, duty_z, aux_z, od_z, vco_z, ref_z}), 0);
        chk("R7 reset zero err/upd", int'({err_z, upd_z}), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_clk(4);

        // R8: shifting with strobe low changes nothing
        updcnt = 0;
        send(mk(3, 0, 3, 7, 300, 99));
        chk("R8 no load while strobe low", updcnt, 0);
        chk_fields("R8 outputs held", 0, 1, 0, 1, 12, 18, 0);

        // R2/R4: example word, single pulse; R9 strobe fall gives nothing
        send(24'h318A3B);
        updcnt = 0;
        strobe();
        chk("R2 one pulse per strobe (R9 fall ignored)", updcnt, 1);
        chk_fields("R4 example decode", 0, 1, 2, 1, 276, 59, 0);

        // R5: illegal VCO code keeps dividers, other fields update
        send(mk(3, 0, 1, 7, 3, 5));
        strobe();
        chk_fields("R5 illegal vco", 3, 0, 1, 7, 276, 59, 1);

        // R5: illegal reference code
        send(mk(1, 1, 0, 2, 100, 0));
        strobe();
        chk_fields("R5 illegal ref", 1, 1, 0, 2, 276, 59, 1);

        // R1 bit order and R5 lower boundary legal
        send(mk(2, 0, 0, 0, 4, 1));
        strobe();
        chk_fields("R1 bit order / R5 boundary", 2, 0, 0, 0, 4, 1, 0);

        // R5 upper values legal
        send(mk(2, 1, 3, 6, 511, 127));
        strobe();
        chk_fields("R5 max codes", 2, 1, 3, 6, 511, 127, 0);

        // R3: transparent mode
        updcnt = 0;
        @(negedge clk); sstb = 1'b1;
        wait_clk(6);
        send(mk(1, 0, 2, 5, 200, 33));
        chk("R3 pulses in transparent mode", updcnt, 25);
        chk_fields("R3 final transparent word", 1, 0, 2, 5, 200, 33, 0);
        @(negedge clk); sstb = 1'b0;
        wait_clk(8);
        chk("R9 strobe fall no pulse", updcnt, 25);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule